// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block runs one cache line refill after a miss. It takes the line address and the offset of the word the processor missed on, asks the lower memory for an eight-beat burst of 64-bit words, and writes each returned word into the cache data array through a line-fill write port. The word the processor asked for goes back on a separate return port one cycle after its beat arrives, so the processor can continue while the rest of the line is still coming in.

A per-miss mode bit picks the burst order. In wrapped mode the burst starts at the missed word and wraps around the line. In natural mode the burst starts at word 0 and runs in order, and the missed word is still forwarded as soon as its beat shows up. A probe port lets a second access to the line being filled find out whether its word is already in the array or whether it has to stall. Only one refill is in flight at a time. Tag lookup and victim choice are handled elsewhere.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: With `miss_wrap`=1 the burst request carries `mem_req_start`=critical offset and `mem_req_wrap`=1. Beat k (k=0..7) is written to word index (offset+k) mod 8.
- R2: With `miss_wrap`=0 the burst request carries `mem_req_start`=0 and `mem_req_wrap`=0. Beat k is written to word index k.
- R3: `cpu_rsp_valid` is high for exactly one cycle per refill. That cycle is the one right after the beat that holds the critical word, and `cpu_rsp_data` equals that beat's data.
- R4: The forward happens before the line is complete: `line_valid` is 0 in the forward cycle.
- R5: Each beat taken with `mem_beat_valid` is presented on the fill port (`fill_we`, `fill_idx`, `fill_data`) in the next cycle. A cycle with no beat produces no write.
- R6: `line_valid` goes to 1 one cycle after the eighth fill write and stays 1 until the next miss is accepted, which clears it.
- R7: `probe_stall` is 1 when `probe_valid` is set, a refill is in progress, `probe_line` matches the line being filled, and word `probe_off` has not yet been written. It is 0 in every other case.
- R8: `miss_ready` is 1 only when no refill is in progress. A miss presented while `miss_ready` is 0 is ignored and starts no burst.
- R9: After reset, `miss_ready` is 1 and `mem_req_valid`, `cpu_rsp_valid`, `fill_we` and `line_valid` are all 0.
- R10: `mem_req_valid` stays high, with a stable start offset, until it is taken with `mem_req_ready`. It then drops in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_off | input | OFF_W | Word offset the processor needs |
| miss_wrap | input | 1 | 1: wrapped burst from the missed word; 0: natural order from word 0 |
| miss_ready | output | 1 | Controller idle, miss accepted this cycle |
| mem_req_valid | output | 1 | Burst request to lower memory |
| mem_req_line | output | LINE_AW | Line address of the burst |
| mem_req_start | output | OFF_W | First word of the burst |
| mem_req_wrap | output | 1 | Burst wraps at the line end |
| mem_req_ready | input | 1 | Lower memory takes the request |
| mem_beat_valid | input | 1 | Burst beat present |
| mem_beat_data | input | WORD_W | Burst beat data |
| cpu_rsp_valid | output | 1 | Critical word return pulse |
| cpu_rsp_data | output | WORD_W | Critical word |
| fill_we | output | 1 | Data array write enable |
| fill_idx | output | OFF_W | Word index within the line |
| fill_data | output | WORD_W | Word to write |
| line_valid | output | 1 | All words of the filled line written |
| probe_valid | input | 1 | Second access to check |
| probe_line | input | LINE_AW | Line address of the second access |
| probe_off | input | OFF_W | Word offset of the second access |
| probe_stall | output | 1 | Second access must wait |

## Verification
The bench runs every critical offset in both modes. For each run it checks the start offset of the request, the array index of each beat, the exact cycle and data of the forward, and the contents of the whole line at the end. A design that always started at word 0, or that wrapped in natural mode, would write beats to the wrong index. One that forwarded after the whole line, or a beat too early, would miss the forward cycle. Offset 7 in natural mode puts the forward in the same cycle as the last write, so that run would catch a `line_valid` that is set too early. Probes of both written and unwritten words, plus a probe of another line, would expose a stall that ignores the write mask or the line match. A miss presented during a refill, a request held back before memory accepts it, and a gap between beats check that no second burst starts, that the request is held, and that the beat counter does not run ahead.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } refill_state_t;
endpackage

// File: rtl/cwf_beat_order.sv
module cwf_beat_order #(
  parameter int BEATS = 8,
  parameter int OFF_W = $clog2(BEATS)
) (
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W-1:0] beat_k,
  input  logic             wrap,
  output logic [OFF_W-1:0] word_idx
);
  localparam bit POW2 = ((1 << OFF_W) == BEATS);

  logic [OFF_W:0] sum;
  assign sum = {1'b0, start} + {1'b0, beat_k};

  generate
    if (POW2) begin : g_pow2
      assign word_idx = wrap ? sum[OFF_W-1:0] : beat_k;
    end else begin : g_mod
      logic [OFF_W:0] wrapped;
      assign wrapped  = (sum >= (OFF_W+1)'(BEATS)) ? sum - (OFF_W+1)'(BEATS) : sum;
      assign word_idx = wrap ? wrapped[OFF_W-1:0] : beat_k;
    end
  endgenerate
endmodule

// File: rtl/cwf_fill_track.sv
module cwf_fill_track #(
  parameter int BEATS = 8,
  parameter int OFF_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic             busy,
  input  logic             probe_valid,
  input  logic             probe_same_line,
  input  logic [OFF_W-1:0] probe_off,
  output logic             line_valid,
  output logic             probe_stall
);
  localparam logic [BEATS-1:0] FULL = {BEATS{1'b1}};

  logic [BEATS-1:0] written_q;
  logic [BEATS-1:0] written_next;

  always_comb begin
    written_next = written_q;
    if (wr_en) written_next[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q  <= '0;
      line_valid <= 1'b0;
    end else if (clear) begin
      written_q  <= '0;
      line_valid <= 1'b0;
    end else begin
      written_q  <= written_next;
      line_valid <= (written_next == FULL);
    end
  end

  assign probe_stall = probe_valid && busy && probe_same_line && !written_q[probe_off];
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int WORD_W  = 64,
  parameter int BEATS   = 8,
  parameter int LINE_AW = 38,
  parameter int OFF_W   = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OFF_W-1:0]   miss_off,
  input  logic               miss_wrap,
  output logic               miss_ready,
  output logic               mem_req_valid,
  output logic [LINE_AW-1:0] mem_req_line,
  output logic [OFF_W-1:0]   mem_req_start,
  output logic               mem_req_wrap,
  input  logic               mem_req_ready,
  input  logic               mem_beat_valid,
  input  logic [WORD_W-1:0]  mem_beat_data,
  output logic               cpu_rsp_valid,
  output logic [WORD_W-1:0]  cpu_rsp_data,
  output logic               fill_we,
  output logic [OFF_W-1:0]   fill_idx,
  output logic [WORD_W-1:0]  fill_data,
  output logic               line_valid,
  input  logic               probe_valid,
  input  logic [LINE_AW-1:0] probe_line,
  input  logic [OFF_W-1:0]   probe_off,
  output logic               probe_stall
);
  import cwf_pkg::*;

  localparam logic [OFF_W-1:0] LAST_K = OFF_W'(BEATS - 1);

  refill_state_t    state_q;
  logic [OFF_W-1:0] crit_q;
  logic [OFF_W-1:0] beat_k_q;
  logic [OFF_W-1:0] beat_idx;
  logic             accept;
  logic             busy;

  assign busy       = (state_q != ST_IDLE) || fill_we;
  assign miss_ready = !busy;
  assign accept     = miss_valid && miss_ready;

  cwf_beat_order #(.BEATS(BEATS), .OFF_W(OFF_W)) u_order (
    .start    (mem_req_start),
    .beat_k   (beat_k_q),
    .wrap     (mem_req_wrap),
    .word_idx (beat_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      crit_q        <= '0;
      beat_k_q      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      mem_req_start <= '0;
      mem_req_wrap  <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_data  <= '0;
      fill_we       <= 1'b0;
      fill_idx      <= '0;
      fill_data     <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      fill_we       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q       <= ST_REQ;
            crit_q        <= miss_off;
            beat_k_q      <= '0;
            mem_req_valid <= 1'b1;
            mem_req_line  <= miss_line;
            mem_req_start <= miss_wrap ? miss_off : '0;
            mem_req_wrap  <= miss_wrap;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (mem_beat_valid) begin
            fill_we   <= 1'b1;
            fill_idx  <= beat_idx;
            fill_data <= mem_beat_data;
            if (beat_idx == crit_q) begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_data  <= mem_beat_data;
            end
            beat_k_q <= beat_k_q + 1'b1;
            if (beat_k_q == LAST_K) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cwf_fill_track #(.BEATS(BEATS), .OFF_W(OFF_W)) u_track (
    .clk             (clk),
    .rst             (rst),
    .clear           (accept),
    .wr_en           (fill_we),
    .wr_idx          (fill_idx),
    .busy            (busy),
    .probe_valid     (probe_valid),
    .probe_same_line (probe_line == mem_req_line),
    .probe_off       (probe_off),
    .line_valid      (line_valid),
    .probe_stall     (probe_stall)
  );
endmodule

// File: rtl/cwf_refill_ctrl_chk.sv
module cwf_refill_ctrl_chk #(
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [OFF_W-1:0] mem_req_start,
  input logic             mem_req_wrap,
  input logic             mem_beat_valid,
  input logic             cpu_rsp_valid,
  input logic             fill_we,
  input logic             line_valid,
  input logic             probe_stall
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_start)); // R10
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R10
  AST_NATURAL_START: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_wrap |-> mem_req_start == '0); // R2
  AST_FWD_EARLY: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> !line_valid); // R4
  AST_FWD_FROM_BEAT: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> $past(mem_beat_valid)); // R3
  AST_FILL_FROM_BEAT: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> $past(mem_beat_valid)); // R5
  AST_LINE_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(line_valid) |-> $past(fill_we)); // R6
  AST_ONE_REFILL: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(miss_valid && miss_ready)); // R8
  AST_STALL_PENDING: assert property (@(posedge clk) disable iff (rst)
    probe_stall |-> !line_valid && !miss_ready); // R7
endmodule

bind cwf_refill_ctrl cwf_refill_ctrl_chk #(.OFF_W(OFF_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .miss_valid     (miss_valid),
  .miss_ready     (miss_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_start  (mem_req_start),
  .mem_req_wrap   (mem_req_wrap),
  .mem_beat_valid (mem_beat_valid),
  .cpu_rsp_valid  (cpu_rsp_valid),
  .fill_we        (fill_we),
  .line_valid     (line_valid),
  .probe_stall    (probe_stall)
);

// File: tb/cwf_refill_ctrl_bench.sv
module cwf_refill_ctrl_bench;
  localparam int WORD_W  = 64;
  localparam int BEATS   = 8;
  localparam int LINE_AW = 38;
  localparam int OFF_W   = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               miss_valid = 1'b0;
  logic [LINE_AW-1:0] miss_line = '0;
  logic [OFF_W-1:0]   miss_off = '0;
  logic               miss_wrap = 1'b0;
  logic               miss_ready;
  logic               mem_req_valid;
  logic [LINE_AW-1:0] mem_req_line;
  logic [OFF_W-1:0]   mem_req_start;
  logic               mem_req_wrap;
  logic               mem_req_ready = 1'b0;
  logic               mem_beat_valid = 1'b0;
  logic [WORD_W-1:0]  mem_beat_data = '0;
  logic               cpu_rsp_valid;
  logic [WORD_W-1:0]  cpu_rsp_data;
  logic               fill_we;
  logic [OFF_W-1:0]   fill_idx;
  logic [WORD_W-1:0]  fill_data;
  logic               line_valid;
  logic               probe_valid = 1'b0;
  logic [LINE_AW-1:0] probe_line = '0;
  logic [OFF_W-1:0]   probe_off = '0;
  logic               probe_stall;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [WORD_W-1:0] ram [BEATS];
  bit written [BEATS];

  always #10 clk = ~clk;

  cwf_refill_ctrl #(.WORD_W(WORD_W), .BEATS(BEATS), .LINE_AW(LINE_AW)) u_cwf_refill_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_off(miss_off),
    .miss_wrap(miss_wrap), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_start(mem_req_start), .mem_req_wrap(mem_req_wrap),
    .mem_req_ready(mem_req_ready),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
    .line_valid(line_valid),
    .probe_valid(probe_valid), .probe_line(probe_line), .probe_off(probe_off),
    .probe_stall(probe_stall)
  );

  always @(posedge clk) if (fill_we) ram[fill_idx] <= fill_data;

  function automatic logic [WORD_W-1:0] pattern(input logic [LINE_AW-1:0] ln, input int w);
    return {ln[31:0] ^ 32'h5A3C_96E1, 32'hC0DE_0000 + 32'(w) * 32'h0001_1111};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic refill(input logic [LINE_AW-1:0] ln, input int off, input bit wrap);
    int fwd_seen = 0;
    for (int i = 0; i < BEATS; i++) written[i] = 1'b0;
    chk(miss_ready == 1'b1, "R8", "idle ready", 64'(miss_ready), 64'd1);
    miss_valid = 1'b1; miss_line = ln; miss_off = OFF_W'(off); miss_wrap = wrap;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(mem_req_valid == 1'b1, wrap ? "R1" : "R2", "req valid", 64'(mem_req_valid), 64'd1);
    chk(mem_req_start == OFF_W'(wrap ? off : 0), wrap ? "R1" : "R2", "req start",
        64'(mem_req_start), 64'(wrap ? off : 0));
    chk(mem_req_wrap == wrap, wrap ? "R1" : "R2", "req wrap", 64'(mem_req_wrap), 64'(wrap));
    chk(mem_req_line == ln, "R1", "req line", 64'(mem_req_line), 64'(ln));
    chk(line_valid == 1'b0, "R6", "cleared on accept", 64'(line_valid), 64'd0);
    chk(probe_stall == 1'b0, "R7", "no probe no stall", 64'(probe_stall), 64'd0);
    if (off % 2 == 0) begin
      @(negedge clk);
      chk(mem_req_valid == 1'b1 && mem_req_start == OFF_W'(wrap ? off : 0), "R10",
          "held without ready", 64'(mem_req_valid), 64'd1);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0, "R10", "drop after take", 64'(mem_req_valid), 64'd0);
    for (int k = 0; k < BEATS; k++) begin
      int idx = wrap ? (off + k) % BEATS : k;
      bit fwd = (idx == off);
      if (wrap && (off % 2 == 1) && k == 4) begin
        mem_beat_valid = 1'b0;
        @(negedge clk);
        chk(fill_we == 1'b0 && cpu_rsp_valid == 1'b0, "R5", "gap no write",
            64'(fill_we), 64'd0);
      end
      mem_beat_valid = 1'b1;
      mem_beat_data = pattern(ln, idx);
      if (k == 2) begin
        miss_valid = 1'b1; miss_line = ln ^ 38'h155; miss_off = 3'd1; miss_wrap = ~wrap;
        #1;
        chk(miss_ready == 1'b0, "R8", "busy not ready", 64'(miss_ready), 64'd0);
      end
      @(negedge clk);
      miss_valid = 1'b0;
      mem_beat_valid = 1'b0;
      chk(fill_we == 1'b1 && fill_idx == OFF_W'(idx), wrap ? "R1" : "R2", "beat index",
          64'(fill_idx), 64'(idx));
      chk(fill_data == pattern(ln, idx), "R5", "fill data", fill_data, pattern(ln, idx));
      chk(cpu_rsp_valid == fwd, "R3", "forward cycle", 64'(cpu_rsp_valid), 64'(fwd));
      if (cpu_rsp_valid) begin
        fwd_seen++;
        chk(cpu_rsp_data == pattern(ln, off), "R3", "forward data", cpu_rsp_data,
            pattern(ln, off));
        chk(line_valid == 1'b0, "R4", "forward before line done", 64'(line_valid), 64'd0);
      end
      chk(line_valid == 1'b0, "R6", "not valid mid fill", 64'(line_valid), 64'd0);
      probe_valid = 1'b1;
      probe_line = (k == 4) ? ln ^ 38'h2A : ln;
      probe_off = OFF_W'((k * 5 + off) % BEATS);
      #1;
      begin
        bit exp_stall = (k != 4) && !written[(k * 5 + off) % BEATS];
        chk(probe_stall == exp_stall, "R7", "probe stall", 64'(probe_stall), 64'(exp_stall));
      end
      probe_valid = 1'b0;
      written[idx] = 1'b1;
    end
    @(negedge clk);
    chk(line_valid == 1'b1, "R6", "line valid after 8 writes", 64'(line_valid), 64'd1);
    chk(fill_we == 1'b0, "R5", "no extra write", 64'(fill_we), 64'd0);
    chk(fwd_seen == 1, "R3", "single forward", 64'(fwd_seen), 64'd1);
    chk(mem_req_valid == 1'b0, "R8", "busy miss ignored", 64'(mem_req_valid), 64'd0);
    for (int w = 0; w < BEATS; w++)
      chk(ram[w] == pattern(ln, w), wrap ? "R1" : "R2", "line contents", ram[w], pattern(ln, w));
    probe_valid = 1'b1; probe_line = ln; probe_off = OFF_W'(off);
    #1;
    chk(probe_stall == 1'b0, "R7", "no stall when idle", 64'(probe_stall), 64'd0);
    probe_valid = 1'b0;
    @(negedge clk);
    chk(line_valid == 1'b1, "R6", "line valid holds", 64'(line_valid), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R9", "reset ready", 64'(miss_ready), 64'd1);
    chk(mem_req_valid == 1'b0 && cpu_rsp_valid == 1'b0, "R9", "reset req/rsp",
        64'(mem_req_valid), 64'd0);
    chk(fill_we == 1'b0 && line_valid == 1'b0, "R9", "reset fill/line", 64'(fill_we), 64'd0);
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < BEATS; o++)
        refill(38'(64'h0ABC_D000 + 64'(m * 97 + o * 13)), o, m == 1);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule